// File: doc/BRIEF.md
# Register-Group Instruction Executor

This block carries out the register-group instructions of a 16-bit accumulator machine in one cycle. It receives the instruction word, the present accumulator (AC) and extension bit (E), and an enable. From these it produces the next AC and E, a one-cycle request to skip the following instruction, and an error strobe for malformed words. It also keeps a halt flag that stays set until reset.

The top four bits of the word select the register group. Within the low twelve bits, each bit stands for exactly one operation. The operations are clear, complement, rotate through E, increment, four condition tests and halt. Next-state, skip and error outputs are combinational from the inputs, so the surrounding sequencer can capture them on the same clock edge. The halt flag is the only register in the block. Once it is set, the unit stops acting on any word until reset.

Top module: `regref_exec_unit`

## Requirements
- R1: The unit acts only when `en` is 1, `instr[15:12]` is 4'b0111 and `halted` is 0. In every other case `ac_out` equals `ac_in`, `e_out` equals `e_in`, and `skip` and `illegal` are 0.
- R2: Bit 11 (word 7800) clears AC to 0. Bit 10 (word 7400) clears E to 0. The register not named by the operation is unchanged.
- R3: Bit 9 (word 7200) inverts every bit of AC. Bit 8 (word 7100) inverts E. The register not named by the operation is unchanged.
- R4: Bit 7 (word 7080) rotates the 17-bit pair {E,AC} right by one place: `e_out` = AC[0] and `ac_out` = {E, AC[15:1]}. Bit 6 (word 7040) rotates the pair left by one place: `e_out` = AC[15] and `ac_out` = {AC[14:0], E}.
- R5: Bit 5 (word 7020) adds 1 to AC modulo 2^16 and leaves E unchanged.
- R6: Bits 4 to 1 are condition tests, and each one leaves AC and E unchanged. Bit 4 (word 7010) raises `skip` when AC[15] is 0, which includes AC = 0. Bit 3 (word 7008) raises `skip` when AC[15] is 1. Bit 2 (word 7004) raises `skip` when AC is 0. Bit 1 (word 7002) raises `skip` when E is 0. `skip` is 1 in the same cycle the word is presented.
- R7: Bit 0 (word 7001) sets `halted` at the next rising clock edge. `halted` then stays 1 until reset.
- R8: A group word with more than one of bits 11 to 0 set raises `illegal` in the same cycle. Such a word leaves AC and E unchanged, does not raise `skip` and does not set `halted`.
- R9: A group word with all of bits 11 to 0 clear (7000) changes nothing and raises no output.
- R10: A synchronous active-high `rst` clears `halted` to 0 at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Execute the presented word this cycle |
| instr | input | 16 | Instruction word |
| ac_in | input | 16 | Present accumulator |
| e_in | input | 1 | Present extension bit |
| ac_out | output | 16 | Next accumulator |
| e_out | output | 1 | Next extension bit |
| skip | output | 1 | Skip the following instruction |
| illegal | output | 1 | Malformed group word seen |
| halted | output | 1 | Sticky halt state |

## Verification
The hardest state to reach is the halted state, because only one exact word sets it and it then hides every later word. The bench reaches it only after the whole vector table has run. That table includes a malformed word that contains the halt bit, so the bench first confirms that this word leaves `halted` at 0. The bench then issues a real halt and shows that a following clear-AC word passes AC through unchanged. Finally it applies reset and confirms that the unit acts again. Vectors with AC = 0 and AC = 8000 test the sign boundary of the two sign tests.

// File: rtl/regref_pkg.sv
package regref_pkg;

    localparam int unsigned WORD_W  = 16;
    localparam int unsigned OP_W    = 12;
    localparam int unsigned GROUP_W = WORD_W - OP_W;
    localparam logic [GROUP_W-1:0] GROUP_CODE = 4'b0111;

    // One bit per operation; field order follows bit 11 down to bit 0.
    typedef struct packed {
        logic clr_ac;
        logic clr_e;
        logic inv_ac;
        logic inv_e;
        logic rot_r;
        logic rot_l;
        logic incr;
        logic tst_pos;
        logic tst_neg;
        logic tst_zero;
        logic tst_ez;
        logic stop;
    } op_t;

    typedef struct packed {
        logic [WORD_W-1:0] ac;
        logic              e;
    } state_t;

    function automatic logic more_than_one(input logic [OP_W-1:0] v);
        return ($countones(v) > 1);
    endfunction

    function automatic logic group_hit(input logic [WORD_W-1:0] w);
        return (w[WORD_W-1 -: GROUP_W] == GROUP_CODE);
    endfunction

endpackage

// File: rtl/regref_decode.sv
module regref_decode
    import regref_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              halted,
    input  logic [WORD_W-1:0] instr,
    output op_t               op,
    output logic              illegal
);
    logic sel;
    logic multi;

    always_comb begin
        sel     = en && !halted && group_hit(instr);
        multi   = more_than_one(instr[OP_W-1:0]);
        illegal = sel && multi;
        op      = (sel && !multi) ? op_t'(instr[OP_W-1:0]) : '0;
    end

    assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (op == '0));

    assert_decode_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(op));

endmodule

// File: rtl/regref_alu.sv
module regref_alu
    import regref_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  op_t    op,
    input  state_t cur,
    output state_t nxt
);
    always_comb begin
        nxt = cur;
        if (op.clr_ac)      nxt.ac = '0;
        else if (op.clr_e)  nxt.e  = 1'b0;
        else if (op.inv_ac) nxt.ac = ~cur.ac;
        else if (op.inv_e)  nxt.e  = ~cur.e;
        else if (op.rot_r)  nxt    = {cur.e, cur.ac};
        else if (op.rot_l)  nxt    = {cur.ac[WORD_W-2:0], cur.e, cur.ac[WORD_W-1]};
        else if (op.incr)   nxt.ac = cur.ac + 1'b1;
    end

    assert_inc_keeps_e_R5: assert property (@(posedge clk) disable iff (rst)
        op.incr |-> (nxt.e == cur.e) && (WORD_W'(nxt.ac - cur.ac) == WORD_W'(1)));

    assert_rot_right_carry_R4: assert property (@(posedge clk) disable iff (rst)
        op.rot_r |-> (nxt.e == cur.ac[0]) && (nxt.ac[WORD_W-1] == cur.e));

    assert_rot_left_carry_R4: assert property (@(posedge clk) disable iff (rst)
        op.rot_l |-> (nxt.e == cur.ac[WORD_W-1]) && (nxt.ac[0] == cur.e));

endmodule

// File: rtl/regref_skip.sv
module regref_skip
    import regref_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  op_t    op,
    input  state_t cur,
    output logic   skip
);
    logic sign;
    logic zero;

    always_comb begin
        sign = cur.ac[WORD_W-1];
        zero = (cur.ac == '0);
        skip = (op.tst_pos  && !sign) ||
               (op.tst_neg  &&  sign) ||
               (op.tst_zero &&  zero) ||
               (op.tst_ez   && !cur.e);
    end

    assert_skip_needs_test_R6: assert property (@(posedge clk) disable iff (rst)
        skip |-> (op.tst_pos || op.tst_neg || op.tst_zero || op.tst_ez));

endmodule

// File: rtl/regref_exec_unit.sv
module regref_exec_unit
    import regref_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic [15:0] instr,
    input  logic [15:0] ac_in,
    input  logic        e_in,
    output logic [15:0] ac_out,
    output logic        e_out,
    output logic        skip,
    output logic        illegal,
    output logic        halted
);
    op_t    op;
    state_t cur;
    state_t nxt;
    logic   halt_q;

    assign cur = '{ac: ac_in, e: e_in};

    regref_decode u_dec (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .halted  (halt_q),
        .instr   (instr),
        .op      (op),
        .illegal (illegal)
    );

    regref_alu u_alu (
        .clk (clk),
        .rst (rst),
        .op  (op),
        .cur (cur),
        .nxt (nxt)
    );

    regref_skip u_skp (
        .clk  (clk),
        .rst  (rst),
        .op   (op),
        .cur  (cur),
        .skip (skip)
    );

    always_ff @(posedge clk) begin
        if (rst)          halt_q <= 1'b0;
        else if (op.stop) halt_q <= 1'b1;
    end

    assign ac_out = nxt.ac;
    assign e_out  = nxt.e;
    assign halted = halt_q;

    assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    assert_idle_passthru_R1: assert property (@(posedge clk) disable iff (rst)
        (!en || halted) |-> (ac_out == ac_in) && (e_out == e_in) && !skip && !illegal);

    assert_skip_no_write_R6: assert property (@(posedge clk) disable iff (rst)
        skip |-> (ac_out == ac_in) && (e_out == e_in));

    assert_illegal_no_halt_R8: assert property (@(posedge clk) disable iff (rst)
        (illegal && !halted) |=> !halted);

endmodule

// File: tb/sim_regref_exec_unit.sv
module sim_regref_exec_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic [15:0] ac_in = 16'h0000;
    logic        e_in = 1'b0;
    logic [15:0] ac_out;
    logic        e_out;
    logic        skip;
    logic        illegal;
    logic        halted;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    regref_exec_unit u0 (
        .clk(clk), .rst(rst), .en(en), .instr(instr), .ac_in(ac_in), .e_in(e_in),
        .ac_out(ac_out), .e_out(e_out), .skip(skip), .illegal(illegal), .halted(halted)
    );

    localparam int NV = 23;
    // {instr, ac_in, e_in, exp_ac, exp_e, exp_skip, exp_illegal}
    localparam logic [51:0] VEC [NV] = '{
        {16'h7800, 16'h1234, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0},
        {16'h7400, 16'h1234, 1'b1, 16'h1234, 1'b0, 1'b0, 1'b0},
        {16'h7200, 16'h00FF, 1'b0, 16'hFF00, 1'b0, 1'b0, 1'b0},
        {16'h7100, 16'h00FF, 1'b0, 16'h00FF, 1'b1, 1'b0, 1'b0},
        {16'h7080, 16'h0001, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0},
        {16'h7080, 16'h8000, 1'b1, 16'hC000, 1'b0, 1'b0, 1'b0},
        {16'h7040, 16'h8000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0},
        {16'h7040, 16'h4001, 1'b1, 16'h8003, 1'b0, 1'b0, 1'b0},
        {16'h7020, 16'hFFFF, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0},
        {16'h7020, 16'h0010, 1'b1, 16'h0011, 1'b1, 1'b0, 1'b0},
        {16'h7010, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0},
        {16'h7010, 16'h8000, 1'b0, 16'h8000, 1'b0, 1'b0, 1'b0},
        {16'h7008, 16'h8000, 1'b0, 16'h8000, 1'b0, 1'b1, 1'b0},
        {16'h7008, 16'h7FFF, 1'b1, 16'h7FFF, 1'b1, 1'b0, 1'b0},
        {16'h7004, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b1, 1'b0},
        {16'h7004, 16'h0001, 1'b0, 16'h0001, 1'b0, 1'b0, 1'b0},
        {16'h7002, 16'h5555, 1'b0, 16'h5555, 1'b0, 1'b1, 1'b0},
        {16'h7002, 16'h5555, 1'b1, 16'h5555, 1'b1, 1'b0, 1'b0},
        {16'h7820, 16'h1234, 1'b1, 16'h1234, 1'b1, 1'b0, 1'b1},
        {16'h7011, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1},
        {16'h3800, 16'h1234, 1'b0, 16'h1234, 1'b0, 1'b0, 1'b0},
        {16'hF800, 16'hABCD, 1'b1, 16'hABCD, 1'b1, 1'b0, 1'b0},
        {16'h7000, 16'hABCD, 1'b1, 16'hABCD, 1'b1, 1'b0, 1'b0}
    };

    function automatic string tag_of(input int i);
        if (i < 2)  return "R2";
        if (i < 4)  return "R3";
        if (i < 8)  return "R4";
        if (i < 10) return "R5";
        if (i < 18) return "R6";
        if (i < 20) return "R8";
        if (i < 22) return "R1";
        return "R9";
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic e, input logic [15:0] w,
                         input logic [15:0] a, input logic ev);
        @(negedge clk);
        en = e; instr = w; ac_in = a; e_in = ev;
        #2;
    endtask

    initial begin
        #3_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R10", "halted after reset", 32'(halted), 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [51:0] v;
            v = VEC[i];
            apply(1'b1, v[51:36], v[35:20], v[19]);
            check(tag_of(i), $sformatf("ac_out vec %0d", i), 32'(ac_out), 32'(v[18:3]));
            check(tag_of(i), $sformatf("e_out vec %0d", i), 32'(e_out), 32'(v[2]));
            check(tag_of(i), $sformatf("skip vec %0d", i), 32'(skip), 32'(v[1]));
            check(tag_of(i), $sformatf("illegal vec %0d", i), 32'(illegal), 32'(v[0]));
        end

        // R8: malformed word carrying the halt bit must not halt
        @(negedge clk);
        check("R8", "halted after malformed halt", 32'(halted), 32'd0);

        // R1: enable low ignores a clear-AC word
        apply(1'b0, 16'h7800, 16'h4321, 1'b1);
        check("R1", "ac_out with en low", 32'(ac_out), 32'h4321);
        check("R1", "e_out with en low", 32'(e_out), 32'd1);

        // R7: halt sets flag at next edge and stays
        apply(1'b1, 16'h7001, 16'h2222, 1'b0);
        check("R7", "ac_out on halt word", 32'(ac_out), 32'h2222);
        check("R7", "halted before edge", 32'(halted), 32'd0);
        apply(1'b1, 16'h7800, 16'h3333, 1'b1);
        check("R7", "halted after edge", 32'(halted), 32'd1);
        check("R1", "ac_out while halted", 32'(ac_out), 32'h3333);
        apply(1'b1, 16'h7004, 16'h0000, 1'b0);
        check("R1", "skip while halted", 32'(skip), 32'd0);
        repeat (3) @(negedge clk);
        check("R7", "halted remains set", 32'(halted), 32'd1);

        // R10: reset clears halt; unit acts again
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10", "halted after reset", 32'(halted), 32'd0);
        apply(1'b1, 16'h7800, 16'h3333, 1'b1);
        check("R10", "ac_out after reset", 32'(ac_out), 32'h0000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule